// File: doc/BRIEF.md
# Programmable-Priority Interrupt Level Resolver

This block gives each of 32 on-chip interrupt sources a software-set 5-bit priority and picks, every clock, the pending source with the highest usable priority. Software programs priorities through a small word-addressed register port. Eight 32-bit registers each hold four priority fields on byte-aligned slots. The gap bits between the fields read as zero.

The resolver looks at the 32 level-sensitive request lines. It drops any source whose priority is 0 or 1 and any source wired to a reserved slot, and picks the winner. Ties go to the lowest source index. The result is registered and presented as a valid flag, the winning level and the winning source index. An interrupt line is raised only when the winning level is strictly above a 5-bit current mask level supplied by the processor side.

Top module: `irq_level_resolver`

## Requirements
- R1: There are eight registers at word addresses 0 to 7. A write with `reg_wr` high stores `reg_wdata` in the addressed register at one clock edge. `reg_rdata` returns the addressed register combinationally.
- R2: In every register, bits 31:29, 23:21, 15:13 and 7:5 read as zero whatever was written.
- R3: After reset, every priority field reads zero and `win_valid`, `win_level`, `win_src` and `irq_out` are all zero.
- R4: A source whose field holds 0 or 1 never wins, even while its request is high.
- R5: Among the qualifying pending sources, the one with the numerically largest field wins. Usable levels run from 2 to 31.
- R6: When several qualifying pending sources share the top level, the lowest source index wins.
- R7: Sources 11, 15, 30 and 31 are reserved. They never win, whatever their request line does, but their fields can still be written and read back.
- R8: `irq_out` is high exactly when a winner exists and its level is strictly greater than `mask_level`.
- R9: The outputs are registered. A change on `irq_req`, `mask_level` or a priority field shows on the outputs after the next clock edge and not before.
- R10: Source n takes its priority from register n/4, slot n%4. Slot 0 is bits 28:24, slot 1 is bits 20:16, slot 2 is bits 12:8 and slot 3 is bits 4:0.
- R11: With no winner, `win_level` and `win_src` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write enable for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register, gap bits zero |
| irq_req | input | 32 | Level-sensitive request, one bit per source |
| mask_level | input | 5 | Current processor mask level |
| win_valid | output | 1 | A qualifying pending source exists |
| win_level | output | 5 | Priority of the winning source |
| win_src | output | 5 | Index of the winning source |
| irq_out | output | 1 | Winner is strictly above the mask level |

## Verification
Request patterns are chosen so that each one separates a single rule from its near neighbours. One pattern has a lone source placed at a non-trivial slot, which catches a wrong field mapping. Others pair sources at levels 1 and 2, or at level 0 against higher levels, which exposes a wrong masking threshold. Sources at equal levels on both sides of a tree split expose a wrong tie order, and a reserved source at level 31 exposes a missing reserved filter. The mask level is swept to just below, equal to and above the winning level, which shows the strict comparison. An output sampled between a stimulus change and the next edge shows the one-cycle register stage.

// File: rtl/irq_prio_pkg.sv
// Package: constants shared by the priority resolver and its checker.
// Assumes fields sit on byte-aligned slots, with slot 0 in the top byte.
package irq_prio_pkg;
    localparam int SLOT_BITS = 8;
    // Source slots that have no request wired: 11, 15, 30, 31
    localparam logic [31:0] DEFAULT_RSV = 32'hC000_8800;
    localparam int MIN_USABLE_LEVEL = 2;
endpackage

// File: rtl/irq_prio_regfile.sv
// Priority register bank: stores one LVL_W-bit field per source and serves
// word reads with the gap bits forced to zero.
// Assumes single-cycle writes and a combinational read of the addressed word.
module irq_prio_regfile
    import irq_prio_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int FPR      = 4,
    parameter int LVL_W    = 5,
    localparam int DATA_W  = FPR * SLOT_BITS,
    localparam int NUM_SRC = NUM_REGS * FPR,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic [NUM_SRC*LVL_W-1:0] fields_flat
);
    logic [LVL_W-1:0]  fld_q   [NUM_SRC];
    logic [DATA_W-1:0] rd_word [NUM_REGS];

    // Purpose: reset all fields to zero, load the addressed register's slots on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) fld_q[i] <= '0;
        end else if (reg_wr) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (reg_addr == ADDR_W'(r)) begin
                    for (int s = 0; s < FPR; s++)
                        fld_q[r*FPR+s] <= reg_wdata[(FPR-1-s)*SLOT_BITS +: LVL_W];
                end
            end
        end
    end

    genvar gr, gs;
    generate
        for (gr = 0; gr < NUM_REGS; gr++) begin : g_word
            // Purpose: assemble one register image with zero gap bits.
            always_comb begin
                rd_word[gr] = '0;
                for (int s = 0; s < FPR; s++)
                    rd_word[gr][(FPR-1-s)*SLOT_BITS +: LVL_W] = fld_q[gr*FPR+s];
            end
        end
        for (gs = 0; gs < NUM_SRC; gs++) begin : g_flat
            assign fields_flat[gs*LVL_W +: LVL_W] = fld_q[gs];
        end
    endgenerate

    // Purpose: select the addressed register image for the read port.
    assign reg_rdata = rd_word[reg_addr];
endmodule

// File: rtl/irq_prio_node.sv
// Comparison node: forwards the higher of two candidates. On equal levels the
// left input (lower source indices) is kept. Level 0 means no candidate.
module irq_prio_node #(
    parameter int LVL_W = 5,
    parameter int IDX_W = 5
) (
    input  logic [LVL_W-1:0] a_lvl,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [LVL_W-1:0] b_lvl,
    input  logic [IDX_W-1:0] b_idx,
    output logic [LVL_W-1:0] o_lvl,
    output logic [IDX_W-1:0] o_idx
);
    // Purpose: pick the right input only when it is strictly higher.
    always_comb begin
        if (b_lvl > a_lvl) begin
            o_lvl = b_lvl;
            o_idx = b_idx;
        end else begin
            o_lvl = a_lvl;
            o_idx = a_idx;
        end
    end
endmodule

// File: rtl/irq_prio_tree.sv
// Combinational resolver: qualifies each source, then reduces the candidates
// through a binary tree of comparison nodes laid out as a heap.
// Assumes NUM_SRC is a power of two. Leaves are placed in index order, so
// left subtrees always hold the lower source indices.
module irq_prio_tree
    import irq_prio_pkg::*;
#(
    parameter int          NUM_SRC = 32,
    parameter int          LVL_W   = 5,
    parameter logic [31:0] RSV     = DEFAULT_RSV,
    localparam int         IDX_W   = $clog2(NUM_SRC),
    localparam int         NODES   = 2 * NUM_SRC - 1
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] fields_flat,
    output logic [LVL_W-1:0]         best_lvl,
    output logic [IDX_W-1:0]         best_idx
);
    logic [LVL_W-1:0] n_lvl [NODES];
    logic [IDX_W-1:0] n_idx [NODES];

    genvar gi, gk;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_leaf
            logic [LVL_W-1:0] fld;
            assign fld = fields_flat[gi*LVL_W +: LVL_W];
            // Purpose: a leaf carries its level only if pending, unreserved and usable.
            always_comb begin
                if (req[gi] && !RSV[gi] && (fld >= LVL_W'(MIN_USABLE_LEVEL)))
                    n_lvl[NUM_SRC-1+gi] = fld;
                else
                    n_lvl[NUM_SRC-1+gi] = '0;
                n_idx[NUM_SRC-1+gi] = IDX_W'(gi);
            end
        end
        for (gk = 0; gk < NUM_SRC - 1; gk++) begin : g_node
            irq_prio_node #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_node (
                .a_lvl (n_lvl[2*gk+1]),
                .a_idx (n_idx[2*gk+1]),
                .b_lvl (n_lvl[2*gk+2]),
                .b_idx (n_idx[2*gk+2]),
                .o_lvl (n_lvl[gk]),
                .o_idx (n_idx[gk])
            );
        end
    endgenerate

    assign best_lvl = n_lvl[0];
    assign best_idx = n_idx[0];
endmodule

// File: rtl/irq_level_resolver.sv
// Top: priority register bank plus the resolver tree, with a registered
// output stage that also compares the winner against the current mask level.
// Assumes all inputs are synchronous to clk.
module irq_level_resolver
    import irq_prio_pkg::*;
#(
    parameter int          NUM_REGS = 8,
    parameter int          FPR      = 4,
    parameter int          LVL_W    = 5,
    parameter logic [31:0] RSV      = DEFAULT_RSV,
    localparam int         DATA_W   = FPR * SLOT_BITS,
    localparam int         NUM_SRC  = NUM_REGS * FPR,
    localparam int         ADDR_W   = $clog2(NUM_REGS),
    localparam int         IDX_W    = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [LVL_W-1:0]  mask_level,
    output logic              win_valid,
    output logic [LVL_W-1:0]  win_level,
    output logic [IDX_W-1:0]  win_src,
    output logic              irq_out
);
    logic [NUM_SRC*LVL_W-1:0] fields_flat;
    logic [LVL_W-1:0]         best_lvl;
    logic [IDX_W-1:0]         best_idx;
    logic                     best_ok;

    irq_prio_regfile #(.NUM_REGS(NUM_REGS), .FPR(FPR), .LVL_W(LVL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fields_flat (fields_flat)
    );

    irq_prio_tree #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .RSV(RSV)) u_tree (
        .req         (irq_req),
        .fields_flat (fields_flat),
        .best_lvl    (best_lvl),
        .best_idx    (best_idx)
    );

    assign best_ok = (best_lvl != '0);

    // Purpose: register the winner and the mask comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_level <= '0;
            win_src   <= '0;
            irq_out   <= 1'b0;
        end else begin
            win_valid <= best_ok;
            win_level <= best_ok ? best_lvl : '0;
            win_src   <= best_ok ? best_idx : '0;
            irq_out   <= best_ok && (best_lvl > mask_level);
        end
    end
endmodule

// File: rtl/irq_level_resolver_chk.sv
// Checker: temporal properties of the resolver outputs and the read port,
// bound to every instance of the top module.
module irq_level_resolver_chk
    import irq_prio_pkg::*;
#(
    parameter logic [31:0] RSV = DEFAULT_RSV
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic [31:0] irq_req,
    input logic [4:0]  mask_level,
    input logic        win_valid,
    input logic [4:0]  win_level,
    input logic [4:0]  win_src,
    input logic        irq_out
);
    AST_GAP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 32'hE0E0_E0E0) == 32'h0); // R2
    AST_LEVEL_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_level >= 5'd2)); // R4
    AST_NO_RESERVED_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((RSV & (32'd1 << win_src)) == 32'h0)); // R7
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (($past(irq_req) & (32'd1 << win_src)) != 32'h0)); // R9
    AST_IRQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (win_valid && (win_level > $past(mask_level)))); // R8
    AST_IRQ_WHEN_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && (win_level > $past(mask_level))) |-> irq_out); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (win_level == 5'd0 && win_src == 5'd0 && !irq_out)); // R11
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !win_valid); // R3
endmodule

bind irq_level_resolver irq_level_resolver_chk #(.RSV(RSV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .irq_req    (irq_req),
    .mask_level (mask_level),
    .win_valid  (win_valid),
    .win_level  (win_level),
    .win_src    (win_src),
    .irq_out    (irq_out)
);

// File: tb/irq_level_resolver_bench.sv
// Scoreboard bench: the driver applies a request pattern and queues the
// expected resolver outputs; the monitor pops and compares after each edge.
module irq_level_resolver_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] RSV_SRC = 32'hC000_8800;

    typedef struct {
        logic       valid;
        logic [4:0] lvl;
        logic [4:0] src;
        logic       irq;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_req = '0;
    logic [4:0]  mask_level = '0;
    logic        win_valid;
    logic [4:0]  win_level;
    logic [4:0]  win_src;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [4:0] model_fld [32];
    exp_t sb_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_level_resolver u_irq_level_resolver (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .mask_level(mask_level), .win_valid(win_valid), .win_level(win_level),
        .win_src(win_src), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Write one register and mirror it into the model (slot s at bits (3-s)*8+4:(3-s)*8)
    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        for (int s = 0; s < 4; s++) model_fld[a*4+s] = d[(3-s)*8 +: 5];
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        reg_addr = 3'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // Driver: apply a pattern at a falling edge and queue what it should produce.
    task automatic apply(input logic [31:0] req, input logic [4:0] msk, input string tag);
        exp_t e;
        logic [4:0] best;
        best = 5'd0;
        e.valid = 1'b0; e.lvl = '0; e.src = '0;
        for (int i = 0; i < 32; i++) begin
            if (req[i] && !RSV_SRC[i] && model_fld[i] >= 5'd2 && model_fld[i] > best) begin
                best = model_fld[i];
                e.valid = 1'b1; e.lvl = model_fld[i]; e.src = 5'(i);
            end
        end
        e.irq = e.valid && (e.lvl > msk);
        e.tag = tag;
        @(negedge clk);
        irq_req = req; mask_level = msk;
        sb_q.push_back(e);
        @(posedge clk);
        #(CLK_PERIOD/2);
    endtask

    // Monitor: compare after each rising edge, away from the edge itself.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " valid"}, 32'(win_valid), 32'(e.valid));
                check({e.tag, " level"}, 32'(win_level), 32'(e.lvl));
                check({e.tag, " src"},   32'(win_src),   32'(e.src));
                check({e.tag, " irq"},   32'(irq_out),   32'(e.irq));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model_fld[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R3: reset state
        #1;
        check("R3 valid after reset", 32'(win_valid), 0);
        check("R3 irq after reset", 32'(irq_out), 0);
        for (int a = 0; a < 8; a++) rd_chk(a, 32'h0, "R3 register reset");
        apply(32'hFFFF_FFFF, 5'd0, "R3 all requests at reset levels");

        // R1/R2: write and read back, gap bits zero
        wr(0, 32'hFFFF_FFFF);
        rd_chk(0, 32'h1F1F_1F1F, "R2 gap bits");
        for (int a = 0; a < 8; a++) wr(a, 32'h0102_0304 + 32'(a) * 32'h0401_0101);
        for (int a = 0; a < 8; a++)
            rd_chk(a, (32'h0102_0304 + 32'(a) * 32'h0401_0101) & 32'h1F1F_1F1F, "R1 readback");
        for (int a = 0; a < 8; a++) wr(a, 32'h0);

        // R10: source 5 is register 1 slot 1 (bits 20:16)
        wr(1, 32'h0007_0000);
        apply(32'hFFFF_FFFF, 5'd0, "R10 slot mapping");
        check("R10 winner src5", 32'(win_src), 5);

        // R4: levels 0 and 1 mask the source
        wr(1, 32'h0001_0000);
        apply(32'h0000_0020, 5'd0, "R4 level 1 masked");
        wr(0, 32'h0002_0000);
        apply(32'h0000_0022, 5'd0, "R4 level 2 usable vs level 1");

        // R5: larger value wins
        wr(2, 32'h0A03_1400);
        apply(32'h0000_0702, 5'd0, "R5 highest level wins");
        apply(32'h0000_0302, 5'd0, "R5 second pattern");

        // R6: ties go to lowest index
        wr(0, 32'h0000_0000);
        wr(1, 32'h0000_0000);
        wr(2, 32'h0000_0000);
        wr(1, 32'h0900_0000);
        wr(5, 32'h0000_0900);
        apply(32'h0040_0010, 5'd0, "R6 tie across halves");
        check("R6 tie winner src4", 32'(win_src), 4);
        apply(32'h0040_0000, 5'd0, "R6 lone higher index");

        // R7: reserved sources never win, fields stay writable
        wr(7, 32'h1F1F_1F1F);
        wr(2, 32'h0000_001F);
        wr(3, 32'h0000_001F);
        rd_chk(7, 32'h1F1F_1F1F, "R7 reserved field writable");
        apply(32'hC000_8800, 5'd0, "R7 reserved only");
        apply(32'hC000_8810, 5'd0, "R7 reserved plus src4");

        // R8: strict compare against mask
        apply(32'h0000_0010, 5'd8, "R8 mask below");
        apply(32'h0000_0010, 5'd9, "R8 mask equal");
        apply(32'h0000_0010, 5'd31, "R8 mask above");

        // R9: a change shows only after the next edge
        apply(32'h0000_0010, 5'd0, "R9 setup");
        irq_req = 32'h0;
        #1;
        check("R9 output holds before edge", 32'(win_valid), 1);
        apply(32'h0, 5'd0, "R9 release");

        // R11: no winner gives zero level and source
        apply(32'h0000_0000, 5'd3, "R11 idle");

        repeat (2) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule